// File: doc/BRIEF.md
# Q31 Fractional Multiplier with Optional Rounding

This block multiplies two signed Q31 fractions (32-bit two's complement values in the range [-1, 1)) and returns a Q31 product. The full 64-bit signed product is doubled to realign the binary point, and the upper word is kept. When rounding is requested, half an output LSB is added before the upper word is taken. Without rounding, the low word is dropped, which truncates toward negative infinity.

Only one operand pair cannot be represented: -1 times -1, which would give +1. That case returns the largest positive Q31 value and raises an overflow pulse.

The unit is a two-stage pipeline. Stage one registers the wide product. Stage two doubles it, applies rounding, selects the saturated value when needed and registers the result. A valid strobe travels alongside the data, so a new operand pair can be accepted on every cycle.

Top module: `q31_frac_mul`

## Requirements
- R1: An operand pair sampled with `in_valid` high at a rising edge yields `res_valid` high after the following rising edge, so results come two edges after the operands are presented. Back-to-back strobes give back-to-back results in the same order, and `res_valid` is low in every other cycle.
- R2: With `rnd_en` low, `res_data` equals bits 63:32 of the signed 64-bit product of `op_a` and `op_b`, shifted left by one.
- R3: With `rnd_en` high, `res_data` equals bits 63:32 of (doubled product + 0x0000_0000_8000_0000).
- R4: When both operands are 0x80000000, `res_data` is 0x7FFFFFFF and `res_ovf` is high, whatever the value of `rnd_en`.
- R5: `res_ovf` is high only in a cycle where `res_valid` is high and the result comes from the saturating case. In every other cycle it is low.
- R6: While `res_valid` is low, `res_data` keeps its last value.
- R7: While `rst_n` is low, `res_valid`, `res_ovf` and `res_data` are all zero.
- R8: Truncation rounds negative results toward negative infinity. For example, 0xFFFFFFFF times 0x40000000 gives 0xFFFFFFFF without rounding and 0x00000000 with rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 32 | First Q31 operand |
| op_b | input | 32 | Second Q31 operand |
| rnd_en | input | 1 | 1 = round to nearest, 0 = truncate |
| res_valid | output | 1 | Result strobe |
| res_data | output | 32 | Q31 result |
| res_ovf | output | 1 | Saturation pulse, aligned with `res_valid` |

## Verification
The saturating pair is a single point among 2^64 operand combinations, so random operands never reach it. The stimulus therefore injects it directly: with and without rounding, back-to-back with ordinary pairs, and next to operands that differ from it by one LSB. Those neighbours give the largest products that must not saturate, and they show that rounding cannot overflow there. The negative results that sit exactly half an LSB below zero are also driven on purpose, because they separate truncation from rounding.

// File: rtl/q31_mul_pkg.sv
package q31_mul_pkg;
  // How stage two forms the output word
  typedef enum logic [1:0] {
    SEL_TRUNC = 2'd0,
    SEL_ROUND = 2'd1,
    SEL_SAT   = 2'd2
  } q31_sel_e;
endpackage

// File: rtl/q31_mul_prod.sv
module q31_mul_prod
  import q31_mul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              rnd_en,
  output logic              s1_valid,
  output logic [PROD_W-1:0] s1_prod,
  output q31_sel_e          s1_sel
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [PROD_W-1:0] a_ext, b_ext, prod_nxt;
  logic              both_neg_one;
  q31_sel_e          sel_nxt;

  always_comb begin
    a_ext        = {{DATA_W{op_a[DATA_W-1]}}, op_a};
    b_ext        = {{DATA_W{op_b[DATA_W-1]}}, op_b};
    prod_nxt     = a_ext * b_ext;
    both_neg_one = (op_a == MOST_NEG) && (op_b == MOST_NEG);
    if (both_neg_one)   sel_nxt = SEL_SAT;
    else if (rnd_en)    sel_nxt = SEL_ROUND;
    else                sel_nxt = SEL_TRUNC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_sel   <= SEL_TRUNC;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod <= prod_nxt;
        s1_sel  <= sel_nxt;
      end
    end
  end
endmodule

// File: rtl/q31_mul_fin.sv
module q31_mul_fin
  import q31_mul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [PROD_W-1:0] s1_prod,
  input  q31_sel_e          s1_sel,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ovf
);
  localparam logic [PROD_W-1:0] HALF_LSB  = {{DATA_W{1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS  = {1'b0, {(DATA_W-1){1'b1}}};

  logic [PROD_W-1:0] dbl, dbl_rnd;
  logic [DATA_W-1:0] data_nxt;
  logic              ovf_nxt;

  always_comb begin
    dbl     = {s1_prod[PROD_W-2:0], 1'b0};
    dbl_rnd = dbl + HALF_LSB;
    unique case (s1_sel)
      SEL_SAT:   data_nxt = MOST_POS;
      SEL_ROUND: data_nxt = dbl_rnd[PROD_W-1:DATA_W];
      default:   data_nxt = dbl[PROD_W-1:DATA_W];
    endcase
    ovf_nxt = s1_valid && (s1_sel == SEL_SAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ovf   <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= s1_valid;
      res_ovf   <= ovf_nxt;
      if (s1_valid) res_data <= data_nxt;
    end
  end
endmodule

// File: rtl/q31_frac_mul.sv
module q31_frac_mul
  import q31_mul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              rnd_en,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ovf
);
  localparam int PROD_W = 2 * DATA_W;

  logic              s1_valid;
  logic [PROD_W-1:0] s1_prod;
  q31_sel_e          s1_sel;

  q31_mul_prod #(.DATA_W(DATA_W)) prod_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .rnd_en   (rnd_en),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_sel   (s1_sel)
  );

  q31_mul_fin #(.DATA_W(DATA_W)) fin_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_prod   (s1_prod),
    .s1_sel    (s1_sel),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_ovf   (res_ovf)
  );
endmodule

// File: rtl/q31_mul_chk.sv
module q31_mul_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              s1_valid,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              res_ovf
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  // R1
  stage1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  // R1
  stage1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_valid);
  // R1
  stage2_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(s1_valid));
  // R4
  sat_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a == MOST_NEG && op_b == MOST_NEG)
      |-> ##2 (res_valid && res_ovf && res_data == MOST_POS));
  // R5
  ovf_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovf |-> res_valid);
  // R4
  ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovf |-> res_data == MOST_POS);
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));
endmodule

bind q31_frac_mul q31_mul_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .s1_valid  (s1_valid),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_ovf   (res_ovf)
);

// File: tb/q31_frac_mul_tb_top.sv
`timescale 1ns/1ps
module q31_frac_mul_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        rnd_en;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_ovf;

  int checks = 0;
  int fails  = 0;

  // bench model pipeline
  logic        m1_v, m2_v;
  logic [31:0] m1_d, m2_d;
  logic        m1_o, m2_o;
  string       m1_tag, m2_tag;

  q31_frac_mul dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .rnd_en(rnd_en), .res_valid(res_valid), .res_data(res_data), .res_ovf(res_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: requirement R2/R3/R4 arithmetic in 64-bit integers
  function automatic logic [32:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic rnd);
    longint p;
    logic [63:0] d;
    if (a == 32'h8000_0000 && b == 32'h8000_0000) return {1'b1, 32'h7FFF_FFFF};
    p = longint'($signed(a)) * longint'($signed(b));
    d = 64'(p) << 1;
    if (rnd) d = d + 64'h0000_0000_8000_0000;
    return {1'b0, d[63:32]};
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic r);
    logic [32:0] e;
    in_valid = v; op_a = a; op_b = b; rnd_en = r;
    @(posedge clk);
    e = ref_mul(a, b, r);
    m2_v = m1_v;
    m2_o = m1_v && m1_o;
    if (m1_v) begin m2_d = m1_d; m2_tag = m1_tag; end
    m1_v = v;
    if (v) begin
      m1_d = e[31:0];
      m1_o = e[32];
      if (e[32])                m1_tag = "R4";
      else if (r)               m1_tag = "R3";
      else if (a[31] ^ b[31])   m1_tag = "R8";
      else                      m1_tag = "R2";
    end
    @(negedge clk);
    chk("R1 valid", {31'b0, res_valid}, {31'b0, m2_v});
    chk("R5 ovf", {31'b0, res_ovf}, {31'b0, m2_o});
    if (m2_v) chk(m2_tag, res_data, m2_d);
    else      chk("R6 hold", res_data, m2_d);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; rnd_en = 1'b0;
    m1_v = 0; m2_v = 0; m1_d = 0; m2_d = 0; m1_o = 0; m2_o = 0;
    m1_tag = "R2"; m2_tag = "R2";
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 valid", {31'b0, res_valid}, 32'd0);
    chk("R7 ovf", {31'b0, res_ovf}, 32'd0);
    chk("R7 data", res_data, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    // R2 basic: 0.5 * 0.5 = 0.25
    step(1, 32'h4000_0000, 32'h4000_0000, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R8 truncation toward -inf and R3 rounding of the same pair
    step(1, 32'hFFFF_FFFF, 32'h4000_0000, 0);
    step(1, 32'hFFFF_FFFF, 32'h4000_0000, 1);
    // R4 saturation in both modes, back to back
    step(1, 32'h8000_0000, 32'h8000_0000, 0);
    step(1, 32'h8000_0000, 32'h8000_0000, 1);
    // neighbours of saturation: must not saturate (R2, R3)
    step(1, 32'h8000_0000, 32'h8000_0001, 1);
    step(1, 32'h8000_0001, 32'h8000_0000, 0);
    step(1, 32'h8000_0000, 32'h7FFF_FFFF, 1);
    step(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1);
    // R6 hold after idle, then R4 again
    step(0, 32'h8000_0000, 32'h8000_0000, 0);
    step(0, 32'h1234_5678, 32'h9ABC_DEF0, 1);
    step(1, 32'h8000_0000, 32'h8000_0000, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R3 exact half LSB cases
    step(1, 32'h0000_0001, 32'h4000_0000, 1);
    step(1, 32'h0000_0001, 32'h4000_0000, 0);
    step(1, 32'h0000_0000, 32'h8000_0000, 1);
    // random mix (R1, R2, R3, R8)
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 37 == 0) begin ra = 32'h8000_0000; rb = 32'h8000_0000; end
      step(($urandom % 4) != 0, ra, rb, $urandom % 2);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule